// File: doc/BRIEF.md
# Reset-Time Configuration Loader

This block sets up the system operating mode each time the external reset line is released. On every low-to-high transition of the reset pin it requests one control byte from a fixed address, 0x00FFF3. The TEST pin, sampled at that transition, selects where the byte comes from: the internal boot ROM, or the external multifunction bus. The byte is stored in an 8-bit control register. The register is decoded into a program-storage select, a bus/normal mode for the multifunction pins, an emulator-bus tristate control, and enables for the internal RAM and CPU. The CPU is held in reset until the byte has arrived.

The block also generates the reset pulse that goes out on the reset pin after an internal reset request. The pulse is either short (16 oscillator clocks) or long (4096 oscillator clocks). The length is chosen from the most significant control bit, the TEST pin and a power-on flag. When the pulse ends the pin rises again, which starts a new fetch. The newly fetched byte therefore chooses both the memory map and the length of the next output pulse.

Top module: `bootcfg_loader`

## Requirements
- R1: One clock edge after the reset-pin input is seen rising, memReq goes high with memAddr = 0x00FFF3. memReq stays high until memAck is sampled high, as long as the pin stays high.
- R2: memSrcExt equals the TEST pin level sampled at that rising edge (0 = internal boot ROM, 1 = external multifunction bus).
- R3: On the edge where memAck is sampled high during a fetch, ctrlReg loads memData. At the same edge configValid rises and cpuRstHold falls. ctrlReg then stays unchanged until the next acknowledged fetch. Bit layout, MSB first: pulse-length select, test toggle, emulator tristate, pin mode, flash select, internal-storage select, RAM enable, CPU enable.
- R4: storeSel is decoded as follows:
  - 2 (external) when bit 2 = 0.
  - 1 (internal flash) when bit 2 = 1 and bit 3 = 1.
  - 0 (boot ROM) when bit 2 = 1 and bit 3 = 0.
  - The value 3 never occurs.
- R5: busMode is decoded as follows:
  - 0 when bit 4 = 1.
  - 1 when bit 4 = 0 and bit 6 = 0.
  - When bit 4 = 0 and bit 6 = 1, busMode equals the inverse of the live TEST pin.
- R6: ramEn = bit 1, cpuEn = bit 0, emuBusTri = bit 5.
- R7: An accepted intRstReq drives rstPinDriveLow for exactly 16 cycles when bit 7 = 1, or exactly 4096 cycles when bit 7 = 0, starting the cycle after the request edge.
- R8: With TEST = 0 every pulse is 4096 cycles. With TEST = 1, the first pulse after power-on reset is 16 cycles whatever bit 7 holds, and later pulses follow R7.
- R9: intRstReq is ignored while a pulse is being driven: the pulse length does not change.
- R10: While the reset pin is low (and no pulse is being driven), configValid is 0 and cpuRstHold is 1 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porRst_n | input | 1 | Asynchronous power-on reset, active low |
| rstPinIn | input | 1 | Synchronized level of the reset pin |
| testPin | input | 1 | TEST pin level |
| intRstReq | input | 1 | Internal reset request |
| memAck | input | 1 | Read acknowledge, data valid |
| memData | input | 8 | Read data |
| memReq | output | 1 | Read request |
| memAddr | output | 24 | Read address |
| memSrcExt | output | 1 | Read source: 1 external bus, 0 boot ROM |
| rstPinDriveLow | output | 1 | Drive the reset pin low |
| configValid | output | 1 | Control register valid |
| cpuRstHold | output | 1 | Hold the CPU in reset |
| ctrlReg | output | 8 | Control register |
| storeSel | output | 2 | Program storage select |
| busMode | output | 1 | Multifunction pins in bus mode |
| emuBusTri | output | 1 | Emulator bus tristate |
| ramEn | output | 1 | Internal RAM enable |
| cpuEn | output | 1 | Internal CPU enable |

## Verification
A control register loaded from the wrong byte would show at once, in the cycle after the acknowledge, on all decoded mode outputs. The bench checks this by sweeping every byte value under both TEST levels and toggling TEST afterwards. A wrong power-on flag or a wrong length select is hidden until the next internal reset; it then shows as a pulse that is 16 cycles long where 4096 were due, or the reverse. The bench therefore measures complete pulses across the power-on, TEST = 0 and TEST = 1 cases. A fetch state left stuck would show as memReq held high, or as configValid never rising.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;
  typedef enum logic [1:0] {
    STORE_BOOT = 2'd0,
    STORE_FLASH = 2'd1,
    STORE_EXT = 2'd2
  } storeT;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_PULSE = 2'd3
  } stateT;

  typedef struct packed {
    logic latchSrc;
    logic loadCfg;
    logic startPulse;
    logic cntDec;
    logic clrPor;
  } strobeT;
endpackage

// File: rtl/bootcfg_ctrl.sv
module bootcfg_ctrl
  import bootcfg_pkg::*;
(
  input  logic   clk,
  input  logic   porRst_n,
  input  logic   rstPinIn,
  input  logic   intRstReq,
  input  logic   memAck,
  input  logic   cntZero,
  output strobeT stb,
  output logic   memReq,
  output logic   configValid,
  output logic   pulseActive
);
  stateT state, stateNxt;
  logic pinQ;
  logic pinRise;

  assign pinRise = rstPinIn & ~pinQ;

  always_comb begin
    stateNxt = state;
    stb = '0;
    unique case (state)
      ST_WAIT: begin
        if (intRstReq) begin
          stateNxt = ST_PULSE;
          stb.startPulse = 1'b1;
        end else if (pinRise) begin
          stateNxt = ST_FETCH;
          stb.latchSrc = 1'b1;
        end
      end
      ST_FETCH: begin
        if (intRstReq) begin
          stateNxt = ST_PULSE;
          stb.startPulse = 1'b1;
        end else if (!rstPinIn) begin
          stateNxt = ST_WAIT;
        end else if (memAck) begin
          stateNxt = ST_RUN;
          stb.loadCfg = 1'b1;
        end
      end
      ST_RUN: begin
        if (intRstReq) begin
          stateNxt = ST_PULSE;
          stb.startPulse = 1'b1;
        end else if (!rstPinIn) begin
          stateNxt = ST_WAIT;
        end
      end
      ST_PULSE: begin
        if (cntZero) begin
          stateNxt = ST_WAIT;
          stb.clrPor = 1'b1;
        end else begin
          stb.cntDec = 1'b1;
        end
      end
      default: stateNxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      state <= ST_WAIT;
      pinQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      pinQ  <= rstPinIn;
    end
  end

  assign memReq      = (state == ST_FETCH);
  assign configValid = (state == ST_RUN);
  assign pulseActive = (state == ST_PULSE);

  // R1
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    memReq && !memAck && rstPinIn && !intRstReq |=> memReq);

  // R10
  pin_low_hold_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    !rstPinIn && !pulseActive && !intRstReq |=> !configValid);

  // R9
  pulse_run_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    pulseActive && !cntZero |=> pulseActive);
endmodule

// File: rtl/bootcfg_dp.sv
module bootcfg_dp
  import bootcfg_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 4096
) (
  input  logic       clk,
  input  logic       porRst_n,
  input  strobeT     stb,
  input  logic [7:0] memData,
  input  logic       testPin,
  input  logic       configValid,
  input  logic       pulseActive,
  output logic [7:0] ctrlReg,
  output logic       cntZero,
  output logic       srcExt,
  output logic [1:0] storeSel,
  output logic       busMode,
  output logic       emuBusTri,
  output logic       ramEn,
  output logic       cpuEn
);
  localparam int CW = $clog2(LONG_LEN);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_LEN - 1);

  localparam int B_LEN = 7;
  localparam int B_TOG = 6;
  localparam int B_TRI = 5;
  localparam int B_MFM = 4;
  localparam int B_FLS = 3;
  localparam int B_INT = 2;
  localparam int B_RAM = 1;
  localparam int B_CPU = 0;

  logic [CW-1:0] cnt;
  logic porFlag;
  logic useShort;
  storeT storeDec;

  always_comb begin
    if (!testPin)      useShort = 1'b0;
    else if (porFlag)  useShort = 1'b1;
    else               useShort = ctrlReg[B_LEN];
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      ctrlReg <= '0;
      cnt     <= '0;
      porFlag <= 1'b1;
      srcExt  <= 1'b0;
    end else begin
      if (stb.latchSrc)   srcExt  <= testPin;
      if (stb.loadCfg)    ctrlReg <= memData;
      if (stb.startPulse) cnt     <= useShort ? SHORT_LOAD : LONG_LOAD;
      else if (stb.cntDec) cnt    <= cnt - 1'b1;
      if (stb.clrPor)     porFlag <= 1'b0;
    end
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    if (!ctrlReg[B_INT])     storeDec = STORE_EXT;
    else if (ctrlReg[B_FLS]) storeDec = STORE_FLASH;
    else                     storeDec = STORE_BOOT;
  end

  assign storeSel  = storeDec;
  assign busMode   = ~ctrlReg[B_MFM] & (~ctrlReg[B_TOG] | ~testPin);
  assign emuBusTri = ctrlReg[B_TRI];
  assign ramEn     = ctrlReg[B_RAM];
  assign cpuEn     = ctrlReg[B_CPU];

  // R3
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    configValid && !stb.loadCfg |=> $stable(ctrlReg));

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    $fell(porFlag) |-> $past(pulseActive));

  // R4
  always_comb begin
    if (porRst_n) store_code_chk: assert (storeSel != 2'd3);
  end
endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
  import bootcfg_pkg::*;
#(
  parameter int SHORT_LEN = 16,
  parameter int LONG_LEN  = 4096,
  parameter logic [23:0] CFG_ADDR = 24'h00FFF3
) (
  input  logic        clk,
  input  logic        porRst_n,
  input  logic        rstPinIn,
  input  logic        testPin,
  input  logic        intRstReq,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        memReq,
  output logic [23:0] memAddr,
  output logic        memSrcExt,
  output logic        rstPinDriveLow,
  output logic        configValid,
  output logic        cpuRstHold,
  output logic [7:0]  ctrlReg,
  output logic [1:0]  storeSel,
  output logic        busMode,
  output logic        emuBusTri,
  output logic        ramEn,
  output logic        cpuEn
);
  strobeT stb;
  logic cntZero;
  logic pulseActive;

  bootcfg_ctrl u_ctrl (
    .clk(clk), .porRst_n(porRst_n), .rstPinIn(rstPinIn),
    .intRstReq(intRstReq), .memAck(memAck), .cntZero(cntZero),
    .stb(stb), .memReq(memReq), .configValid(configValid),
    .pulseActive(pulseActive)
  );

  bootcfg_dp #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dp (
    .clk(clk), .porRst_n(porRst_n), .stb(stb), .memData(memData),
    .testPin(testPin), .configValid(configValid), .pulseActive(pulseActive),
    .ctrlReg(ctrlReg), .cntZero(cntZero), .srcExt(memSrcExt),
    .storeSel(storeSel), .busMode(busMode), .emuBusTri(emuBusTri),
    .ramEn(ramEn), .cpuEn(cpuEn)
  );

  assign memAddr        = CFG_ADDR;
  assign rstPinDriveLow = pulseActive;
  assign cpuRstHold     = ~configValid;
endmodule

// File: tb/tb_bootcfg_loader.sv
module tb_bootcfg_loader;
  logic clk = 0;
  logic porRst_n = 0;
  logic extLow = 1;
  logic testPin = 0;
  logic intRstReq = 0;
  logic memAck = 0;
  logic [7:0] memData = '0;
  logic rstPinIn;
  logic memReq, memSrcExt, rstPinDriveLow, configValid, cpuRstHold;
  logic busMode, emuBusTri, ramEn, cpuEn;
  logic [23:0] memAddr;
  logic [7:0] ctrlReg;
  logic [1:0] storeSel;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  assign rstPinIn = !(extLow || rstPinDriveLow);

  bootcfg_loader dut (
    .clk(clk), .porRst_n(porRst_n), .rstPinIn(rstPinIn), .testPin(testPin),
    .intRstReq(intRstReq), .memAck(memAck), .memData(memData),
    .memReq(memReq), .memAddr(memAddr), .memSrcExt(memSrcExt),
    .rstPinDriveLow(rstPinDriveLow), .configValid(configValid),
    .cpuRstHold(cpuRstHold), .ctrlReg(ctrlReg), .storeSel(storeSel),
    .busMode(busMode), .emuBusTri(emuBusTri), .ramEn(ramEn), .cpuEn(cpuEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expStore(input logic [7:0] c);
    return !c[2] ? 2 : (c[3] ? 1 : 0);
  endfunction

  function automatic bit expBus(input logic [7:0] c, input logic t);
    return !c[4] && (!c[6] || !t);
  endfunction

  // wait for memReq, check it, acknowledge with code
  task automatic serveFetch(input logic [7:0] code, input logic expSrc);
    int n = 0;
    while (!memReq && n < 10000) begin @(negedge clk); n++; end
    check(memReq == 1'b1, "R1 memReq", memReq, 1);
    check(memAddr == 24'h00FFF3, "R1 memAddr", memAddr, 24'h00FFF3);
    check(memSrcExt == expSrc, "R2 memSrcExt", memSrcExt, expSrc);
    check(configValid == 1'b0 && cpuRstHold == 1'b1, "R10 hold during fetch", configValid, 0);
    @(negedge clk);
    check(memReq == 1'b1, "R1 memReq held", memReq, 1);
    memAck = 1; memData = code;
    @(negedge clk);
    memAck = 0;
    check(ctrlReg == code, "R3 ctrlReg", ctrlReg, code);
    check(configValid == 1'b1 && cpuRstHold == 1'b0, "R3 configValid", configValid, 1);
    check(memReq == 1'b0, "R1 memReq drop", memReq, 0);
  endtask

  task automatic doLoad(input logic [7:0] code, input logic t, input logic [7:0] prev);
    testPin = t;
    extLow = 1;
    @(negedge clk); @(negedge clk);
    check(configValid == 1'b0 && cpuRstHold == 1'b1, "R10 pin low", configValid, 0);
    check(ctrlReg == prev, "R3 ctrlReg retained", ctrlReg, prev);
    extLow = 0;
    @(negedge clk);
    serveFetch(code, t);
  endtask

  task automatic doPulse(input int expLen, input logic [7:0] nextCode, input string req);
    int len = 0;
    intRstReq = 1;
    @(negedge clk);
    intRstReq = 0;
    while (rstPinDriveLow && len < 10000) begin
      len++;
      intRstReq = (len == 5);
      @(negedge clk);
    end
    intRstReq = 0;
    check(len == expLen, req, len, expLen);
    serveFetch(nextCode, testPin);
  endtask

  task automatic sweepCode(input logic [7:0] c, input logic t, input logic [7:0] prev);
    doLoad(c, t, prev);
    check(storeSel == expStore(c), "R4 storeSel", storeSel, expStore(c));
    check(busMode == expBus(c, t), "R5 busMode", busMode, expBus(c, t));
    check({emuBusTri, ramEn, cpuEn} == {c[5], c[1], c[0]}, "R6 enables",
          {emuBusTri, ramEn, cpuEn}, {c[5], c[1], c[0]});
    testPin = !t;
    #1;
    check(busMode == expBus(c, !t), "R5 live TEST", busMode, expBus(c, !t));
    testPin = t;
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    testPin = 1;
    repeat (3) @(negedge clk);
    check(configValid == 0 && cpuRstHold == 1 && memReq == 0 && rstPinDriveLow == 0,
          "R10 reset state", configValid, 0);
    check(ctrlReg == 8'h00, "R3 reset ctrlReg", ctrlReg, 0);
    porRst_n = 1;
    @(negedge clk);
    // TEST=1: first pulse after power-on short even with bit7=0
    doLoad(8'h2B, 1'b1, 8'h00);
    check(storeSel == 2 && busMode == 1, "R4 R5 code 2B bus mode", storeSel, 2);
    doPulse(16, 8'h2B, "R8 first pulse short");
    doPulse(4096, 8'hAB, "R7 long pulse, R9 req ignored");
    doPulse(16, 8'hAB, "R7 short pulse, R9 req ignored");
    // TEST=0 always long
    testPin = 0;
    doPulse(4096, 8'hFF, "R8 TEST=0 long");
    check(storeSel == 1 && busMode == 0 && cpuEn && ramEn, "R4 R6 code FF standalone", storeSel, 1);
    doPulse(4096, 8'hDF, "R8 TEST=0 long with bit7 set");
    check(storeSel == 1 && emuBusTri == 0 && busMode == 0, "R4 R6 code DF emulator", storeSel, 1);
    // new power-on with TEST=0: first pulse still long
    porRst_n = 0; extLow = 1;
    @(negedge clk);
    porRst_n = 1;
    doLoad(8'hFF, 1'b0, 8'h00);
    doPulse(4096, 8'hFF, "R8 power-on with TEST=0 long");
    // sweep all codes under both TEST levels
    prev = 8'hFF;
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 256; c++) begin
        sweepCode(8'(c), t[0], prev);
        prev = 8'(c);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule